// File: doc/BRIEF.md
# Configurable GPIO Port with Input Filter and Pin Interrupts

This block is an 8-bit general-purpose I/O port controller. Software reaches it through a small register bus: a write strobe with address and data, and a read path whose data is registered one cycle after the address is presented. Per-pin registers hold the output value, the direction, the pull-up enable, the open-drain enable, the filter enable and the alternate-function selection. Registered controls go out to external pad cells as output enable, output data, pull-up enable and open-drain mode.

Pad inputs are first retimed by a two-flop synchronizer. On the upper four pins, an optional glitch filter accepts a new level only after it has been seen on four consecutive sample ticks. The sample tick comes from a shared generator that software points at the system clock, the clock divided by 4, the clock divided by 4096, or an externally supplied slow tick. The filtered level feeds the read path and an edge detector. The edge detector sets a sticky per-pin flag on rising edges, falling edges, or both. Software clears a flag by writing 1 to its bit, and the interrupt line is high while any flag is set.

Register map (4-bit address): 0 output/pin level, 1 direction, 2 pull-up, 3 open-drain, 4 filter enable, 5 alternate function, 6 rise enable, 7 fall enable, 8 interrupt flags, 9 filter rate.

Top module: `gpio_port`

## Requirements
- R1: With direction bit 1 and open-drain bit 0, the pin is driven: pad_oe is 1 and pad_do equals the written output bit. With direction bit 0, pad_oe is 0.
- R2: A read of address 0 returns the written output bit for pins whose direction is 1 and the synchronized (or filtered) pad level for pins whose direction is 0.
- R3: Pull-up bit 1 drives pad_pu high for that pin and bit 0 drives it low. All pull-up bits are 0 after reset.
- R4: With direction 1 and open-drain bit 1, output bit 0 gives pad_oe 1 and pad_do 0, and output bit 1 gives pad_oe 0 (pin released). pad_od mirrors the open-drain register.
- R5: After reset, every pin is an input (pad_oe 0), push-pull (pad_od 0), unfiltered, with all interrupt flags clear and irq low.
- R6: The alternate-function register appears on alt_sel and is 00h after reset.
- R7: Only filter-enable bits [7:4] are implemented. Bits [3:0] read back 0, and pins 3..0 are never filtered: a one-cycle pulse on them is still seen.
- R8: A filtered pin takes a new level only after the synchronized input has held it for 4 consecutive sample ticks. A pulse lasting 3 ticks is ignored, and one lasting 4 ticks is accepted.
- R9: The filter rate at address 9, bits [1:0], selects the sample tick: 0 every clock, 1 every 4 clocks, 2 every 4096 clocks, 3 each pulse of slow_tick.
- R10: A rising edge on a pin with its rise-enable bit set, or a falling edge with its fall-enable bit set, sets that pin's flag. Flags stay set, and irq is high while any flag is set.
- R11: Writing address 8 clears exactly the flags whose data bits are 1. The other flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse from a slow time base, in the clk domain |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered from bus_addr |
| pad_in | input | 8 | Raw pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output data |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_od | output | 8 | Per-pin open-drain mode |
| alt_sel | output | 8 | Per-pin alternate-function select |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions assume that reset is held for at least one clock edge and that slow_tick is already a clean pulse in the clk domain. They also assume that pad_in changes are caught by the synchronizer and do not take part in any checked relation. The bench changes pad_in and every bus input only on the falling clock edge, so pulse widths are whole clock cycles that the synchronizer keeps intact. slow_tick is driven as isolated one-cycle pulses well after the pad level has settled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] REG_DATA  = 4'd0;
  localparam logic [ADDR_W-1:0] REG_DIR   = 4'd1;
  localparam logic [ADDR_W-1:0] REG_PULL  = 4'd2;
  localparam logic [ADDR_W-1:0] REG_ODRN  = 4'd3;
  localparam logic [ADDR_W-1:0] REG_FILT  = 4'd4;
  localparam logic [ADDR_W-1:0] REG_ALT   = 4'd5;
  localparam logic [ADDR_W-1:0] REG_RISE  = 4'd6;
  localparam logic [ADDR_W-1:0] REG_FALL  = 4'd7;
  localparam logic [ADDR_W-1:0] REG_FLAG  = 4'd8;
  localparam logic [ADDR_W-1:0] REG_RATE  = 4'd9;

  typedef enum logic [1:0] {
    RATE_FULL  = 2'd0,
    RATE_QUART = 2'd1,
    RATE_LONG  = 2'd2,
    RATE_SLOW  = 2'd3
  } rate_e;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen
  import gpio_pkg::*;
#(
  parameter int DIV_SHORT = 4,
  parameter int DIV_LONG  = 4096
) (
  input  logic  clk,
  input  logic  rst,
  input  rate_e rate,
  input  logic  slow_tick,
  output logic  tick
);
  localparam int CNT_W = $clog2(DIV_LONG);

  logic [CNT_W-1:0] div_cnt;
  logic             short_hit;
  logic             long_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
    end else if (div_cnt == CNT_W'(DIV_LONG - 1)) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_comb begin
    short_hit = ((div_cnt % CNT_W'(DIV_SHORT)) == CNT_W'(DIV_SHORT - 1));
    long_hit  = (div_cnt == CNT_W'(DIV_LONG - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= 1'b0;
    end else begin
      unique case (rate)
        RATE_FULL:  tick <= 1'b1;
        RATE_QUART: tick <= short_hit;
        RATE_LONG:  tick <= long_hit;
        default:    tick <= slow_tick;
      endcase
    end
  end

  // R9: full-rate selection yields a tick on every following cycle
  assert_tick_full_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rate) != RATE_FULL) || tick));

  // R9: slow-tick selection passes only the external pulse
  assert_tick_slow_R9: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_SLOW && !slow_tick) |=> !tick);
endmodule

// File: rtl/gpio_filter.sv
module gpio_filter #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(HOLD_TICKS) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      run_cnt <= '0;
    end else if (tick) begin
      if (din == dout) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(HOLD_TICKS - 1)) begin
        dout    <= din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R8: the filtered level only moves on a sample tick
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dout));

  // R8: an input that agrees with the output never changes it
  assert_hold_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (din == dout) |=> $stable(dout));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PINS       = 8,
  parameter int FILT_LSB   = 4,
  parameter int HOLD_TICKS = 4,
  parameter int DIV_SHORT  = 4,
  parameter int DIV_LONG   = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_do,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_od,
  output logic [PINS-1:0]   alt_sel,
  output logic              irq
);
  localparam logic [PINS-1:0] FILT_MASK = {PINS{1'b1}} << FILT_LSB;

  logic [PINS-1:0] out_q, dir_q, pu_q, od_q, filt_q, alt_q, rise_q, fall_q, flag_q;
  rate_e           rate_q;
  logic [PINS-1:0] sync1_q, sync2_q, prev_q, pin_lvl;
  logic [PINS-1:0] filt_lvl;
  logic [PINS-1:0] edge_set, clr_mask;
  logic            tick;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      pu_q   <= '0;
      od_q   <= '0;
      filt_q <= '0;
      alt_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      rate_q <= RATE_FULL;
    end else if (bus_we) begin
      unique case (bus_addr)
        REG_DATA: out_q  <= bus_wdata;
        REG_DIR:  dir_q  <= bus_wdata;
        REG_PULL: pu_q   <= bus_wdata;
        REG_ODRN: od_q   <= bus_wdata;
        REG_FILT: filt_q <= bus_wdata & FILT_MASK;
        REG_ALT:  alt_q  <= bus_wdata;
        REG_RISE: rise_q <= bus_wdata;
        REG_FALL: fall_q <= bus_wdata;
        REG_RATE: rate_q <= rate_e'(bus_wdata[1:0]);
        default: ;
      endcase
    end
  end

  // input retiming
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  gpio_tick_gen #(
    .DIV_SHORT (DIV_SHORT),
    .DIV_LONG  (DIV_LONG)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .rate      (rate_q),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i >= FILT_LSB) begin : g_filt
      gpio_filter #(.HOLD_TICKS(HOLD_TICKS)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .din  (sync2_q[i]),
        .dout (filt_lvl[i])
      );
      assign pin_lvl[i] = filt_q[i] ? filt_lvl[i] : sync2_q[i];
    end else begin : g_raw
      assign filt_lvl[i] = sync2_q[i];
      assign pin_lvl[i]  = sync2_q[i];
    end
  end

  // edge detection and sticky flags
  always_comb begin
    edge_set = (pin_lvl & ~prev_q & rise_q) | (~pin_lvl & prev_q & fall_q);
    clr_mask = (bus_we && bus_addr == REG_FLAG) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= pin_lvl;
      flag_q <= (flag_q & ~clr_mask) | edge_set;
    end
  end

  // registered pad controls and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe    <= '0;
      pad_do    <= '0;
      pad_pu    <= '0;
      pad_od    <= '0;
      alt_sel   <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      pad_oe  <= dir_q & ~(od_q & out_q);
      pad_do  <= out_q & ~od_q;
      pad_pu  <= pu_q;
      pad_od  <= od_q;
      alt_sel <= alt_q;
      irq     <= |flag_q;
      unique case (bus_addr)
        REG_DATA: bus_rdata <= (dir_q & out_q) | (~dir_q & pin_lvl);
        REG_DIR:  bus_rdata <= dir_q;
        REG_PULL: bus_rdata <= pu_q;
        REG_ODRN: bus_rdata <= od_q;
        REG_FILT: bus_rdata <= filt_q;
        REG_ALT:  bus_rdata <= alt_q;
        REG_RISE: bus_rdata <= rise_q;
        REG_FALL: bus_rdata <= fall_q;
        REG_FLAG: bus_rdata <= flag_q;
        REG_RATE: bus_rdata <= PINS'(rate_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R1: a pin is only ever driven when its direction bit was set
  assert_oe_needs_dir_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(dir_q)) == '0));

  // R4: an open-drain pin holding a 1 is released
  assert_od_release_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(od_q & out_q)) == '0));

  // R10/R11: a flag only drops when software wrote 1 to its bit
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_mask)) == '0));

  // R10: irq follows the presence of any flag one cycle later
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|flag_q)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  import gpio_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_do, pad_pu, pad_od, alt_sel;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
    .pad_od(pad_od), .alt_sel(alt_sel), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_pin(input int bitn, input int cycles);
    @(negedge clk);
    pad_in[bitn] = 1'b1;
    idle(cycles);
    pad_in[bitn] = 1'b0;
    idle(8);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    check("R5 pad_oe", pad_oe, 8'h00);
    check("R5 pad_od", pad_od, 8'h00);
    check("R3 pad_pu reset", pad_pu, 8'h00);
    check("R6 alt_sel reset", alt_sel, 8'h00);
    check("R5 irq", {7'd0, irq}, 8'h00);
    rd(REG_FILT, v); check("R5 filter enable", v, 8'h00);
    rd(REG_FLAG, v); check("R5 flags", v, 8'h00);
  endtask

  task automatic test_push_pull();
    logic [7:0] v;
    wr(REG_DATA, 8'hA5);
    wr(REG_DIR, 8'h0F);
    idle(2);
    check("R1 pad_oe", pad_oe, 8'h0F);
    check("R1 pad_do", pad_do, 8'hA5);
    pad_in = 8'h3C;
    idle(4);
    rd(REG_DATA, v);
    check("R2 mixed read", v, 8'h35);
    pad_in = 8'h00;
    wr(REG_DIR, 8'h00);
    idle(2);
    check("R1 input pins undriven", pad_oe, 8'h00);
  endtask

  task automatic test_pull_alt();
    wr(REG_PULL, 8'h81);
    wr(REG_ALT, 8'h5A);
    idle(2);
    check("R3 pad_pu", pad_pu, 8'h81);
    check("R6 alt_sel", alt_sel, 8'h5A);
    wr(REG_PULL, 8'h00);
    idle(2);
    check("R3 pad_pu cleared", pad_pu, 8'h00);
  endtask

  task automatic test_open_drain();
    wr(REG_DIR, 8'hFF);
    wr(REG_ODRN, 8'hF0);
    wr(REG_DATA, 8'h3C);
    idle(2);
    check("R4 pad_oe", pad_oe, 8'hCF);
    check("R4 pad_do", pad_do, 8'h0C);
    check("R4 pad_od", pad_od, 8'hF0);
    wr(REG_ODRN, 8'h00);
    wr(REG_DIR, 8'h00);
    idle(2);
  endtask

  task automatic test_filter_low_nibble();
    logic [7:0] v;
    wr(REG_FILT, 8'hFF);
    rd(REG_FILT, v); check("R7 filter bits readback", v, 8'hF0);
    wr(REG_RISE, 8'hFF);
    pulse_pin(1, 1);
    rd(REG_FLAG, v); check("R7 low pin unfiltered pulse", v, 8'h02);
    idle(1);
    check("R10 irq high", {7'd0, irq}, 8'h01);
    wr(REG_FLAG, 8'h02);
    idle(2);
    check("R11 irq low after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic test_filter_full_rate();
    logic [7:0] v;
    wr(REG_RATE, 8'h00);
    pulse_pin(5, 3);
    rd(REG_FLAG, v); check("R8 3-tick pulse rejected", v, 8'h00);
    pulse_pin(5, 4);
    rd(REG_FLAG, v); check("R8 4-tick pulse accepted", v, 8'h20);
    wr(REG_FLAG, 8'hFF);
  endtask

  task automatic test_filter_quarter();
    logic [7:0] v;
    wr(REG_RATE, 8'h01);
    idle(4);
    pulse_pin(6, 12);
    rd(REG_FLAG, v); check("R9 div4 12 cycles rejected", v, 8'h00);
    pulse_pin(6, 16);
    idle(12);
    rd(REG_FLAG, v); check("R9 div4 16 cycles accepted", v, 8'h40);
    wr(REG_FLAG, 8'hFF);
  endtask

  task automatic test_filter_long();
    logic [7:0] v;
    wr(REG_RATE, 8'h02);
    pulse_pin(7, 3 * 4096);
    idle(4100 * 4);
    rd(REG_FLAG, v); check("R9 div4096 3 periods rejected", v, 8'h00);
    pulse_pin(7, 4 * 4096);
    idle(4100 * 4);
    rd(REG_FLAG, v); check("R9 div4096 4 periods accepted", v, 8'h80);
    wr(REG_FLAG, 8'hFF);
  endtask

  task automatic test_filter_slow();
    logic [7:0] v;
    wr(REG_RATE, 8'h03);
    @(negedge clk); pad_in[4] = 1'b1;
    idle(6);
    for (int k = 0; k < 3; k++) begin
      slow_tick = 1'b1; idle(1); slow_tick = 1'b0; idle(5);
    end
    rd(REG_FLAG, v); check("R9 slow 3 pulses no change", v, 8'h00);
    slow_tick = 1'b1; idle(1); slow_tick = 1'b0; idle(5);
    rd(REG_FLAG, v); check("R9 slow 4th pulse accepted", v, 8'h10);
    rd(REG_DATA, v); check("R2 filtered level read", v & 8'h10, 8'h10);
    wr(REG_FLAG, 8'hFF);
    wr(REG_FILT, 8'h00);
    @(negedge clk); pad_in[4] = 1'b0;
    idle(6);
    wr(REG_FLAG, 8'hFF);
    wr(REG_RATE, 8'h00);
  endtask

  task automatic test_edges();
    logic [7:0] v;
    wr(REG_RISE, 8'h01);
    wr(REG_FALL, 8'h06);
    wr(REG_FLAG, 8'hFF);
    @(negedge clk); pad_in[2:0] = 3'b111;
    idle(6);
    rd(REG_FLAG, v); check("R10 rise only on enabled pin", v, 8'h01);
    @(negedge clk); pad_in[2:0] = 3'b000;
    idle(6);
    rd(REG_FLAG, v); check("R10 fall flags added", v, 8'h07);
    wr(REG_FLAG, 8'h04);
    rd(REG_FLAG, v); check("R11 selective clear", v, 8'h03);
    check("R10 irq still high", {7'd0, irq}, 8'h01);
    wr(REG_FLAG, 8'h03);
    idle(2);
    check("R11 all cleared irq low", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    test_reset();
    test_push_pull();
    test_pull_alt();
    test_open_drain();
    test_filter_low_nibble();
    test_filter_full_rate();
    test_filter_quarter();
    test_filter_long();
    test_filter_slow();
    test_edges();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule